// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Read

This block is a small single-clock SRAM whose control inputs are all captured on the rising clock edge. A burst begins when either of two active-low address strobes loads an external address. After that, a 2-bit step counter produces up to four word addresses inside the aligned 4-word block that holds the start address. An active-low advance input moves the counter forward by one step. A static order input chooses between two address sequences: linear, where the low two bits count up modulo 4, and interleaved, where the low two bits are the start value XORed with the step count.

Reads are flow-through. The array output follows the registered address combinationally, so no output register sits in the path. The data pins are modelled as a read-data port plus a pad drive enable. The drive enable responds combinationally to the output enable. Writes are captured at the edge with a per-lane mask, and the array is updated at the following edge.

Top module: `sburst_sram`

## Requirements
- R1: The device is selected at a burst start only when primary_n=0, second=1 and third_n=0 are all true together. A start made with any of the three inactive deselects the device until the next start.
- R2: A start with pstrb_n_i=0 takes effect only while ce_n_i=0. A start with cstrb_n_i=0 takes effect whatever ce_n_i is. A start loads addr_i and resets the step to 0, and it takes precedence over the advance input.
- R3: Read data for the current burst address is on rdata_o in the same cycle in which that address was registered, with no extra cycle of latency.
- R4: With order_i=0 the low two address bits run start+k modulo 4 for step k=0..3.
- R5: With order_i=1 the low two address bits run start XOR k for step k=0..3.
- R6: When no start occurs, adv_n_i=0 increments the step by one. When adv_n_i=1 the step holds, so the same word is accessed again.
- R7: The step wraps after four accesses. The address bits above bit 1 never change except at a start.
- R8: drive_o is 1 only while the device is selected, the current cycle is not a write, and oe_n_i=0. oe_n_i acts without waiting for a clock edge. drive_o is 0 during reset.
- R9: Lane i occupies data bits [i*LANE_W +: LANE_W]. In a selected cycle with all_we_n_i=1, lane i is written exactly when lane_we_n_i[i]=0, and the other lanes keep their contents.
- R10: all_we_n_i=0 writes every lane whatever lane_we_n_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address loaded at a burst start |
| wdata_i | input | LANES*LANE_W | Write data |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Second chip enable, active high |
| ce3_n_i | input | 1 | Third chip enable, active low |
| pstrb_n_i | input | 1 | Address strobe gated by ce_n_i, active low |
| cstrb_n_i | input | 1 | Ungated address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| all_we_n_i | input | 1 | Write all lanes, active low |
| order_i | input | 1 | 0 linear, 1 interleaved burst order |
| oe_n_i | input | 1 | Output enable, asynchronous, active low |
| rdata_o | output | LANES*LANE_W | Flow-through read data |
| drive_o | output | 1 | Pad drive enable for the data bus |

## Verification
Two pairs of events can fall in the same cycle. The first is a strobe and an advance: the bench asserts both together and expects the load to win, so the data seen is that of the newly loaded address rather than the next step. The second is a write followed directly by a read: the array update lands on the same edge that registers the read, and the bench judges the flow-through data of that read against its byte-lane memory model. The bench also applies a strobe gated off by the primary enable in the middle of a burst and expects the burst word to be repeated.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       interleave);
    return interleave ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr_o
);
  import sbs_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      step_q <= '0;
    end else if (adv_i) begin
      step_q <= step_q + 2'd1;
    end
  end

  assign cur_addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_q, order_i)};

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (step_q == 2'd0) && (base_q == $past(addr_i)));
  p_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> step_q == $past(step_q) + 2'd1);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(cur_addr_o));
  p_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cur_addr_o[ADDR_W-1:2]));
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ce_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              pstrb_n_i,
  input  logic              cstrb_n_i,
  input  logic              adv_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  input  logic              all_we_n_i,
  input  logic              order_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              start, ce_ok, sel_d, sel_q, wr_q;
  logic [LANES-1:0]  lanes_d, lanes_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] cur_addr;

  assign start   = (!pstrb_n_i && !ce_n_i) || !cstrb_n_i;
  assign ce_ok   = !ce_n_i && ce2_i && !ce3_n_i;
  assign sel_d   = start ? ce_ok : sel_q;
  assign lanes_d = !all_we_n_i ? {LANES{1'b1}} : ~lane_we_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      lanes_q <= '0;
      wdata_q <= '0;
    end else begin
      sel_q   <= sel_d;
      wr_q    <= sel_d && (|lanes_d);
      lanes_q <= sel_d ? lanes_d : '0;
      wdata_q <= wdata_i;
    end
  end

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .adv_i      (!adv_n_i),
    .order_i    (order_i),
    .addr_i     (addr_i),
    .cur_addr_o (cur_addr)
  );

  // late write: array updated at the edge after capture, at the captured address
  sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_q ? lanes_q : '0),
    .addr_i  (cur_addr),
    .wdata_i (wdata_q),
    .rdata_o (rdata_o)
  );

  assign drive_o = sel_q && !wr_q && !oe_n_i;

  p_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !ce_ok) |=> !drive_o);
  p_wr_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_d && !all_we_n_i) |=> !drive_o);
  p_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !drive_o);
endmodule

// File: tb/sim_sburst_sram.sv
module sim_sburst_sram;
  localparam int AW = 6, NL = 2, LW = 9, DW = NL * LW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic ce_n_i = 1'b0, ce2_i = 1'b1, ce3_n_i = 1'b0;
  logic pstrb_n_i = 1'b1, cstrb_n_i = 1'b1, adv_n_i = 1'b1;
  logic [NL-1:0] lane_we_n_i = '1;
  logic all_we_n_i = 1'b1, order_i = 1'b0, oe_n_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic drive_o;

  always #5 clk = ~clk;

  sburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (.clk_i(clk), .*);

  typedef struct { logic drv; logic [DW-1:0] data; string req; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = '0;
  logic          m_sel = 1'b0;
  logic [DW-1:0] m_mem [1<<AW];

  task automatic cyc(input logic pn, cn, an, cen, ce2, ce3n,
                     input logic [AW-1:0] a, input logic [NL-1:0] ln,
                     input logic alln, input logic [DW-1:0] wd,
                     input logic oen, ordr, input string req);
    logic start, wr;
    logic [1:0] low;
    logic [NL-1:0] lanes;
    logic [AW-1:0] cur;
    exp_t e;
    @(negedge clk);
    pstrb_n_i = pn; cstrb_n_i = cn; adv_n_i = an; ce_n_i = cen; ce2_i = ce2;
    ce3_n_i = ce3n; addr_i = a; lane_we_n_i = ln; all_we_n_i = alln;
    wdata_i = wd; oe_n_i = oen; order_i = ordr;
    start = (!pn && !cen) || !cn;
    if (start) begin
      m_base = a; m_step = 2'd0; m_sel = !cen && ce2 && !ce3n;
    end else if (!an) m_step = m_step + 2'd1;
    low = ordr ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step);
    cur = {m_base[AW-1:2], low};
    lanes = !alln ? '1 : ~ln;
    wr = m_sel && (|lanes);
    if (wr)
      for (int l = 0; l < NL; l++)
        if (lanes[l]) m_mem[cur][l*LW +: LW] = wd[l*LW +: LW];
    e.drv = m_sel && !wr && !oen;
    e.data = m_mem[cur];
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: outputs settle after the edge that registers the pushed cycle
  initial forever begin
    @(posedge clk);
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (drive_o !== e.drv) begin
        fails++;
        $display("FAIL %s drive_o act=%0b exp=%0b", e.req, drive_o, e.drv);
      end
      if (e.drv) begin
        checks++;
        if (rdata_o !== e.data) begin
          fails++;
          $display("FAIL %s rdata_o act=%h exp=%h", e.req, rdata_o, e.data);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #3;
    checks++;
    if (drive_o !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset drive_o act=%0b exp=0", drive_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    // R10: global write words 0..7, lane enables deliberately off
    for (int i = 0; i < 8; i++)
      cyc(1,0,1, 0,1,0, AW'(i), '1, 0, DW'(18'h1_0000 + i*18'h0_1111), 0, 0, "R10");
    // R3 R4 R7: linear burst from 5 -> 5,6,7,4
    cyc(0,1,1, 0,1,0, 6'd5, '1, 1, '0, 0, 0, "R3");
    cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 0, "R4");
    cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 0, "R4");
    cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 0, "R7");
    cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 0, "R7");
    // R6: hold
    cyc(1,1,1, 0,1,0, 6'd0, '1, 1, '0, 0, 0, "R6");
    // R2: gated strobe with primary enable off is ignored
    cyc(0,1,1, 1,1,0, 6'd2, '1, 1, '0, 0, 0, "R2");
    // R2: strobe and advance together, load wins
    cyc(1,0,0, 0,1,0, 6'd1, '1, 1, '0, 0, 0, "R2");
    // R5: interleaved from 6 -> 6,7,4,5
    cyc(1,0,1, 0,1,0, 6'd6, '1, 1, '0, 0, 1, "R5");
    for (int i = 0; i < 3; i++)
      cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 1, "R5");
    cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 1, "R7");
    // R8: asynchronous output enable off
    cyc(1,1,1, 0,1,0, 6'd0, '1, 1, '0, 1, 0, "R8");
    // R1: deselect via second and third enables
    cyc(1,0,1, 0,0,0, 6'd3, '1, 1, '0, 0, 0, "R1");
    cyc(1,1,0, 0,1,0, 6'd0, '1, 1, '0, 0, 0, "R1");
    cyc(1,0,1, 0,1,1, 6'd3, '1, 1, '0, 0, 0, "R1");
    cyc(1,0,1, 0,1,0, 6'd3, '1, 1, '0, 0, 0, "R1");
    // R9: write lane 0 only at 2, then lane 1 only at 3, read back
    cyc(1,0,1, 0,1,0, 6'd2, 2'b10, 1, 18'h2AB_CD, 0, 0, "R9");
    cyc(1,0,1, 0,1,0, 6'd3, 2'b01, 1, 18'h3F0_0F, 0, 0, "R9");
    cyc(1,0,1, 0,1,0, 6'd2, '1, 1, '0, 0, 0, "R9");
    cyc(1,0,1, 0,1,0, 6'd3, '1, 1, '0, 0, 0, "R9");
    // R3: write then immediate read of the same word
    cyc(1,0,1, 0,1,0, 6'd4, 2'b00, 1, 18'h1234_5, 0, 0, "R3");
    cyc(1,0,1, 0,1,0, 6'd4, '1, 1, '0, 0, 0, "R3");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule